// File: doc/BRIEF.md
# DMA Trigger Selection and Channel Arbiter

This block sits in front of a shared DMA transfer engine that serves three channels. For each channel it picks one line from a sixteen-entry trigger bus and turns it into a request. The line can be a software request, the completion flag of channel 0 (so that channels can be chained), an external pin or a peripheral event. Each request is taken either on a rising edge or for as long as the line is high. Among the requesting channels the arbiter picks one, using fixed priority or rotating priority. It then hands a single transfer grant, tagged with the channel index, to the engine, and issues no further grant until the engine reports that the transfer is done.

Two system policies apply on top of arbitration.

- **Start on fetch:** this option holds back a pending start until the next instruction-fetch strobe.
- **NMI abort:** when this option is enabled, a non-maskable interrupt that arrives during a transfer lets that transfer finish. It then flags the channel as aborted and blocks the channel from further grants until software disables it.

Independently of arbitration, the block turns the per-channel completion flags into a prioritised interrupt vector value.

Top module: `dma_trig_arb`

## Requirements
- R1: While reset is active and right after it, `grant_o` and `abort_o` are 0, `grant_ch_o` is 0, and `iv_o` is 0 when no completion flag is set.
- R2: Select code 0 takes the channel's trigger from `sw_req_i[c]`. A one-cycle strobe on an enabled channel is latched, and the latch clears when that channel is granted, so each strobe yields exactly one grant.
- R3: Select codes 1 to 13 and code 15 take the trigger from `trig_src_i[code]`. Code 14 takes it from completion flag `ifg_i[0]`, which chains channel 0 into another channel.
- R4: With the channel's level bit at 0, each rising edge of the selected line (compared against its value in the previous cycle) latches one request, held until granted; a line held high gives one grant. With the level bit at 1, the channel requests in every cycle the line is high.
- R5: With `rotate_i`=0, the lowest-numbered eligible channel wins.
- R6: With `rotate_i`=1, the channel granted last has the lowest priority in the next arbitration; out of reset channel 0 has the highest.
- R7: A grant is a one-cycle pulse of `grant_o`, one cycle after the arbitration decision. No new grant is issued until `xfer_done_i` has been seen high after the previous grant.
- R8: With `on_fetch_i`=1, a grant is issued only for a decision taken in a cycle where `fetch_i` is high. With `on_fetch_i`=0, a decision is taken as soon as the engine is idle.
- R9: With `nmi_en_i`=1, an `nmi_i` pulse during a transfer lets the transfer finish, sets `abort_o` for the channel being served, and blocks that channel from further grants. The flag clears, and the block is lifted, once the channel's enable bit is low.
- R10: While a channel's enable bit is low, its triggers and software strobes are neither acted on nor remembered, and enabling the channel later produces no grant from them.
- R11: `iv_o` is 0 when no flag in `ifg_i` is set; otherwise it is 2, 4 or 6 for the lowest-numbered set flag (channel 0, 1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_src_i | input | 16 | Trigger bus; bit k is used by select code k (codes 1-13, 15) |
| sw_req_i | input | 3 | Software start strobe per channel |
| ch_sel_i | input | 12 | Four-bit trigger select per channel, channel c in bits [4c+3:4c] |
| ch_en_i | input | 3 | Channel enable |
| ch_level_i | input | 3 | 1 = level sensitive, 0 = rising edge |
| rotate_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| on_fetch_i | input | 1 | 1 = start only on an instruction-fetch strobe |
| nmi_en_i | input | 1 | 1 = an NMI aborts the channel being served |
| nmi_i | input | 1 | Non-maskable interrupt pulse |
| fetch_i | input | 1 | Instruction-fetch strobe |
| xfer_done_i | input | 1 | Engine reports the granted transfer finished |
| ifg_i | input | 3 | Completion flags per channel |
| grant_o | output | 1 | One-cycle transfer grant |
| grant_ch_o | output | 2 | Channel index of the current grant |
| abort_o | output | 3 | Abort flag per channel |
| iv_o | output | 8 | Interrupt vector value |

## Verification
The bench targets these corner cases:

- **Edge line held high:** the line must give one grant, not one grant per cycle. A design that confused edge and level would keep granting.
- **Fixed versus rotating order:** a broken pointer would let channel 0 starve the other channels, or would repeat the last winner.
- **NMI mid-transfer:** a design that dropped the transfer would miss the done handshake. A design that ignored the abort would keep granting the aborted channel.
- **Disabled channels, deferred start and chaining:** a trigger seen while disabled must not be remembered; a start must wait for the fetch strobe; the chained channel must follow channel 0's flag. A model of each rule, compared in every cycle, exposes a start that fires early or a pending request that leaks through.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned SEL_SW_CODE    = 0;
  localparam int unsigned SEL_CHAIN_CODE = 14;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dma_trig_cond.sv
module dma_trig_cond
  import dma_arb_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int TRIG_N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              level_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [TRIG_N-1:0] trig_src_i,
  input  logic              chain_i,
  input  logic              sw_req_i,
  input  logic              gnt_i,
  output logic              req_o
);
  logic raw, prev_q, pend_q, sw_q, is_sw;

  assign is_sw = (sel_i == SEL_W'(SEL_SW_CODE));

  always_comb begin
    if (is_sw)                              raw = 1'b0;
    else if (sel_i == SEL_W'(SEL_CHAIN_CODE)) raw = chain_i;
    else                                    raw = trig_src_i[sel_i];
  end

  // set wins over a coincident grant; disabled channel forgets everything
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      sw_q   <= 1'b0;
    end else begin
      prev_q <= raw;
      pend_q <= en_i & ((raw & ~prev_q) | (pend_q & ~gnt_i));
      sw_q   <= en_i & (sw_req_i | (sw_q & ~gnt_i));
    end
  end

  assign req_o = en_i & (is_sw ? sw_q : (level_i ? raw : pend_q));

  // R10
  disabled_forget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pend_q && !sw_q));
  // R2
  sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_q && gnt_i && !sw_req_i) |=> !sw_q);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NUM_CH = 3,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rotate_i,
  input  logic [CH_W-1:0]   last_i,
  output logic [CH_W-1:0]   win_o,
  output logic              any_o
);
  always_comb begin
    int base, idx;
    win_o = '0;
    any_o = 1'b0;
    base  = rotate_i ? int'(last_i) + 1 : 0;
    if (base >= NUM_CH) base = 0;
    for (int k = 0; k < NUM_CH; k++) begin
      idx = base + k;
      if (idx >= NUM_CH) idx = idx - NUM_CH;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        win_o = CH_W'(idx);
      end
    end
  end

  // R5
  always_comb begin
    win_valid_chk: assert (!any_o || req_i[win_o]);
  end
endmodule

// File: rtl/dma_ivec.sv
module dma_ivec #(
  parameter int NUM_CH = 3,
  parameter int IV_W   = 8
) (
  input  logic [NUM_CH-1:0] flag_i,
  output logic [IV_W-1:0]   iv_o
);
  always_comb begin
    iv_o = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (flag_i[c]) iv_o = IV_W'((c + 1) * 2);
  end

  // R11
  always_comb begin
    iv_even_chk: assert (iv_o[0] == 1'b0);
  end
endmodule

// File: rtl/dma_trig_arb.sv
module dma_trig_arb
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = 4,
  parameter int TRIG_N = 16,
  parameter int IV_W   = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TRIG_N-1:0]       trig_src_i,
  input  logic [NUM_CH-1:0]       sw_req_i,
  input  logic [NUM_CH*SEL_W-1:0] ch_sel_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic [NUM_CH-1:0]       ch_level_i,
  input  logic                    rotate_i,
  input  logic                    on_fetch_i,
  input  logic                    nmi_en_i,
  input  logic                    nmi_i,
  input  logic                    fetch_i,
  input  logic                    xfer_done_i,
  input  logic [NUM_CH-1:0]       ifg_i,
  output logic                    grant_o,
  output logic [CH_W-1:0]         grant_ch_o,
  output logic [NUM_CH-1:0]       abort_o,
  output logic [IV_W-1:0]         iv_o
);
  arb_state_e        state_q;
  logic [NUM_CH-1:0] req, elig, gnt_vec, abort_q, abort_set;
  logic [CH_W-1:0]   win, gch_q, last_q;
  logic              any, issue, grant_q, busy;

  assign busy = (state_q == ARB_BUSY);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_trig_cond #(.SEL_W(SEL_W), .TRIG_N(TRIG_N)) u_cond (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (ch_en_i[c]),
      .level_i    (ch_level_i[c]),
      .sel_i      (ch_sel_i[c*SEL_W +: SEL_W]),
      .trig_src_i (trig_src_i),
      .chain_i    (ifg_i[0]),
      .sw_req_i   (sw_req_i[c]),
      .gnt_i      (gnt_vec[c]),
      .req_o      (req[c])
    );
    assign gnt_vec[c]   = issue && (win == CH_W'(c));
    assign abort_set[c] = busy && nmi_en_i && nmi_i && (gch_q == CH_W'(c));

    // R9
    abort_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_q[c] |=> !(grant_o && grant_ch_o == CH_W'(c)));
    // R9
    abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en_i[c] |=> !abort_o[c]);
  end

  assign elig = req & ~abort_q;

  dma_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req_i    (elig),
    .rotate_i (rotate_i),
    .last_i   (last_q),
    .win_o    (win),
    .any_o    (any)
  );

  assign issue = !busy && any && (!on_fetch_i || fetch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      grant_q <= 1'b0;
      gch_q   <= '0;
      last_q  <= CH_W'(NUM_CH - 1);
      abort_q <= '0;
    end else begin
      grant_q <= issue;
      abort_q <= ch_en_i & (abort_q | abort_set);
      if (issue) begin
        state_q <= ARB_BUSY;
        gch_q   <= win;
        last_q  <= win;
      end else if (busy && xfer_done_i) begin
        state_q <= ARB_IDLE;
      end
    end
  end

  dma_ivec #(.NUM_CH(NUM_CH), .IV_W(IV_W)) u_ivec (
    .flag_i (ifg_i),
    .iv_o   (iv_o)
  );

  assign grant_o    = grant_q;
  assign grant_ch_o = gch_q;
  assign abort_o    = abort_q;

  // R7
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !xfer_done_i) |=> !grant_o);
  // R8
  fetch_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_fetch_i && !fetch_i) |=> !grant_o);
endmodule

// File: tb/tb_dma_trig_arb.sv
module tb_dma_trig_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int WDOG = 5000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [15:0] trig_src = '0;
  logic [2:0]  sw_req = '0, ch_en = '0, ch_level = '0, ifg = '0;
  logic [11:0] ch_sel = '0;
  logic        rotate = 0, on_fetch = 0, nmi_en = 0, nmi = 0, fetch = 0, xfer_done = 0;
  logic        grant_o;
  logic [1:0]  grant_ch_o;
  logic [2:0]  abort_o;
  logic [7:0]  iv_o;

  int n_chk = 0, n_bad = 0, done_lat = 1, dcnt = 0;
  bit run_cmp = 0;
  string tag = "R1";
  int gcount[NCH];
  int glog[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_trig_arb dut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_src_i(trig_src), .sw_req_i(sw_req),
    .ch_sel_i(ch_sel), .ch_en_i(ch_en), .ch_level_i(ch_level), .rotate_i(rotate),
    .on_fetch_i(on_fetch), .nmi_en_i(nmi_en), .nmi_i(nmi), .fetch_i(fetch),
    .xfer_done_i(xfer_done), .ifg_i(ifg), .grant_o(grant_o), .grant_ch_o(grant_ch_o),
    .abort_o(abort_o), .iv_o(iv_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // reference model state
  bit m_prev[NCH], m_pend[NCH], m_sw[NCH], m_abort[NCH];
  bit m_busy, m_gnt;
  int m_gch, m_last;

  always @(posedge clk or negedge rst_ni) begin : ref_model
    int sel, win, base, idx;
    bit found, issue, gc;
    bit raw_v[NCH];
    bit elig_v[NCH];
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++) begin
        m_prev[c] = 0; m_pend[c] = 0; m_sw[c] = 0; m_abort[c] = 0;
      end
      m_busy = 0; m_gnt = 0; m_gch = 0; m_last = NCH - 1;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        sel = int'(ch_sel[c*4 +: 4]);
        raw_v[c] = (sel == 0) ? 1'b0 : (sel == 14) ? ifg[0] : trig_src[sel];
        elig_v[c] = ch_en[c] && !m_abort[c] &&
                    ((sel == 0) ? m_sw[c] : (ch_level[c] ? raw_v[c] : m_pend[c]));
      end
      base = rotate ? (m_last + 1) % NCH : 0;
      found = 0; win = 0;
      for (int k = 0; k < NCH; k++) begin
        idx = (base + k) % NCH;
        if (!found && elig_v[idx]) begin found = 1; win = idx; end
      end
      issue = !m_busy && found && (!on_fetch || fetch);
      for (int c = 0; c < NCH; c++) begin
        gc = issue && (win == c);
        m_abort[c] = ch_en[c] && (m_abort[c] || (m_busy && nmi_en && nmi && m_gch == c));
        m_sw[c]    = ch_en[c] && (sw_req[c] || (m_sw[c] && !gc));
        m_pend[c]  = ch_en[c] && ((raw_v[c] && !m_prev[c]) || (m_pend[c] && !gc));
        m_prev[c]  = raw_v[c];
      end
      m_gnt = issue;
      if (issue) begin m_gch = win; m_last = win; end
      m_busy = issue || (m_busy && !xfer_done);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    int exp_iv;
    logic [2:0] exp_ab;
    if (rst_ni && run_cmp) begin
      exp_iv = 0;
      for (int c = NCH - 1; c >= 0; c--) if (ifg[c]) exp_iv = (c + 1) * 2;
      for (int c = 0; c < NCH; c++) exp_ab[c] = m_abort[c];
      chk(grant_o === m_gnt, "grant", int'(grant_o), int'(m_gnt));
      chk(int'(grant_ch_o) == m_gch, "grant_ch", int'(grant_ch_o), m_gch);
      chk(abort_o === exp_ab, "abort", int'(abort_o), int'(exp_ab));
      chk(int'(iv_o) == exp_iv, "iv", int'(iv_o), exp_iv);
      if (grant_o) begin
        gcount[grant_ch_o]++;
        glog.push_back(int'(grant_ch_o));
      end
    end
  end

  // transfer engine stand-in
  always @(posedge clk) begin
    #1;
    xfer_done = 0;
    if (grant_o) dcnt = done_lat;
    if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) xfer_done = 1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr_log();
    for (int c = 0; c < NCH; c++) gcount[c] = 0;
    glog.delete();
  endtask

  task automatic set_sel(input int ch, input int code);
    ch_sel[ch*4 +: 4] = 4'(code);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    summary();
    $finish;
  end

  initial begin
    // R1: reset values
    cyc(3);
    @(negedge clk);
    chk(grant_o === 1'b0, "R1 reset grant", int'(grant_o), 0);
    chk(abort_o === 3'b0, "R1 reset abort", int'(abort_o), 0);
    chk(grant_ch_o === 2'b0, "R1 reset ch", int'(grant_ch_o), 0);
    chk(iv_o === 8'h0, "R1 reset iv", int'(iv_o), 0);
    @(posedge clk); #1;
    rst_ni = 1; run_cmp = 1;
    cyc(2);

    // R2: software strobe, one grant per strobe
    tag = "R2"; clr_log();
    set_sel(0, 0); ch_en = 3'b001;
    sw_req = 3'b001; cyc(1); sw_req = 0; cyc(8);
    chk(gcount[0] == 1, "R2 sw grants", gcount[0], 1);

    // R3: bus line, external code 15, chain code 14
    tag = "R3"; clr_log();
    ch_en = 3'b110; set_sel(1, 5); set_sel(2, 15); ch_level = 0;
    cyc(2);
    trig_src[5] = 1; cyc(1); trig_src[5] = 0; cyc(6);
    trig_src[15] = 1; cyc(1); trig_src[15] = 0; cyc(6);
    set_sel(1, 14); cyc(2);
    ifg[0] = 1; cyc(6); ifg[0] = 0; cyc(4);
    chk(gcount[1] == 2, "R3 ch1 grants", gcount[1], 2);
    chk(gcount[2] == 1, "R3 ch2 grants", gcount[2], 1);

    // R4: edge held high gives one grant; level keeps requesting
    tag = "R4"; clr_log();
    set_sel(1, 5); ch_en = 3'b010; cyc(2);
    trig_src[5] = 1; cyc(12); trig_src[5] = 0; cyc(3);
    chk(gcount[1] == 1, "R4 edge held high", gcount[1], 1);
    clr_log();
    ch_en = 3'b100; ch_level = 3'b100; cyc(1);
    trig_src[15] = 1; cyc(8); trig_src[15] = 0; cyc(4);
    chk(gcount[2] >= 3, "R4 level repeats", gcount[2], 3);
    ch_level = 0;

    // R5: fixed priority order
    tag = "R5"; clr_log();
    set_sel(0, 0); set_sel(1, 0); set_sel(2, 0); ch_en = 3'b111; rotate = 0;
    cyc(2);
    sw_req = 3'b111; cyc(1); sw_req = 0; cyc(10);
    chk(glog.size() == 3, "R5 grant count", glog.size(), 3);
    if (glog.size() >= 3) begin
      chk(glog[0] == 0, "R5 first", glog[0], 0);
      chk(glog[1] == 1, "R5 second", glog[1], 1);
      chk(glog[2] == 2, "R5 third", glog[2], 2);
    end

    // R6: rotating priority with all channels level-requesting
    tag = "R6"; clr_log();
    set_sel(0, 3); set_sel(1, 3); set_sel(2, 3); ch_level = 3'b111; rotate = 1;
    cyc(2);
    trig_src[3] = 1; cyc(14); trig_src[3] = 0; cyc(4);
    chk(glog.size() >= 4, "R6 grant count", glog.size(), 4);
    if (glog.size() >= 4) begin
      chk(glog[0] == 0, "R6 rot0", glog[0], 0);
      chk(glog[1] == 1, "R6 rot1", glog[1], 1);
      chk(glog[2] == 2, "R6 rot2", glog[2], 2);
      chk(glog[3] == 0, "R6 rot3", glog[3], 0);
    end
    rotate = 0;

    // R7: long transfers hold off new grants
    tag = "R7"; clr_log();
    ch_en = 3'b001; done_lat = 5; cyc(2);
    trig_src[3] = 1; cyc(20); trig_src[3] = 0; cyc(8);
    chk(gcount[0] >= 3 && gcount[0] <= 4, "R7 spaced grants", gcount[0], 4);
    done_lat = 1; ch_level = 0;

    // R8: start deferred to fetch strobe
    tag = "R8"; clr_log();
    set_sel(0, 0); on_fetch = 1; cyc(2);
    sw_req = 3'b001; cyc(1); sw_req = 0; cyc(6);
    chk(gcount[0] == 0, "R8 waits for fetch", gcount[0], 0);
    fetch = 1; cyc(1); fetch = 0; cyc(4);
    chk(gcount[0] == 1, "R8 starts on fetch", gcount[0], 1);
    on_fetch = 0;

    // R9: NMI during a transfer
    tag = "R9"; clr_log();
    ch_en = 3'b010; set_sel(1, 3); ch_level = 3'b010; nmi_en = 1; done_lat = 4;
    cyc(2);
    trig_src[3] = 1; cyc(2);
    nmi = 1; cyc(1); nmi = 0; cyc(10);
    chk(abort_o == 3'b010, "R9 abort set", int'(abort_o), 2);
    chk(gcount[1] == 1, "R9 blocked after abort", gcount[1], 1);
    ch_en = 3'b000; cyc(2);
    chk(abort_o == 3'b000, "R9 abort cleared", int'(abort_o), 0);
    trig_src[3] = 0; ch_level = 0; nmi_en = 0; done_lat = 1; cyc(2);

    // R10: triggers on disabled channel not remembered
    tag = "R10"; clr_log();
    set_sel(0, 7); cyc(2);
    trig_src[7] = 1; cyc(1); trig_src[7] = 0; cyc(2);
    ch_en = 3'b001; cyc(6);
    chk(gcount[0] == 0, "R10 edge forgotten", gcount[0], 0);
    ch_en = 0; set_sel(0, 0); cyc(1);
    sw_req = 3'b001; cyc(1); sw_req = 0; cyc(1);
    ch_en = 3'b001; cyc(6);
    chk(gcount[0] == 0, "R10 strobe forgotten", gcount[0], 0);
    ch_en = 0;

    // R11: vector priority
    tag = "R11";
    ifg = 3'b000; cyc(1); chk(iv_o == 8'd0, "R11 none", int'(iv_o), 0);
    ifg = 3'b100; cyc(1); chk(iv_o == 8'd6, "R11 ch2", int'(iv_o), 6);
    ifg = 3'b110; cyc(1); chk(iv_o == 8'd4, "R11 ch1", int'(iv_o), 4);
    ifg = 3'b111; cyc(1); chk(iv_o == 8'd2, "R11 ch0", int'(iv_o), 2);
    ifg = 3'b010; cyc(1); chk(iv_o == 8'd4, "R11 ch1 only", int'(iv_o), 4);
    ifg = 0; cyc(3);

    summary();
    $finish;
  end
endmodule